// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block passes data between an A port and a B port through two latch banks, one per direction. The data path is cut into byte-wide sections, and each section has its own six active-low controls: a chip enable, a latch enable and an output enable for the A-to-B direction, and the same three for the B-to-A direction. With every section wired to the same controls the block acts as one wide transceiver. With separate controls it acts as several independent byte transceivers.

The latches are modelled synchronously. On each rising clock edge a bank whose chip enable and latch enable are both low takes the value on its source port. In every other case the bank keeps its contents. Tri-state is shown as a data bus plus one active-high drive-enable bit per output bit. A section drives its destination port only while its chip enable and output enable for that direction are both low. A per-section flag reports when both directions of a section drive at the same time. An asynchronous active-low reset clears the banks and holds every drive enable off.

Top module: `dual_lat_xcvr`

## Requirements
- R1: While rst_n is low, every latch bit reads 0 on b_out and a_out, and every bit of b_drv, a_drv and clash is 0, whatever the controls are.
- R2: When a2b_ce_n[s] and a2b_le_n[s] are both 0 at a rising clock edge, section s of the A-to-B bank loads a_in bits [s*8+7:s*8]. That value is on the same bits of b_out after that edge.
- R3: When a2b_ce_n[s] is 0 and a2b_le_n[s] is 1 at an edge, section s of the A-to-B bank keeps its value, whatever a_in does.
- R4: When a2b_ce_n[s] is 1 at an edge, section s of the A-to-B bank keeps its value, whatever a2b_le_n[s] and a_in are.
- R5: The eight bits of b_drv for section s are all 1 exactly when a2b_ce_n[s] and a2b_oe_n[s] are both 0 and reset is inactive. Otherwise they are all 0. This follows the inputs within the same cycle.
- R6: The B-to-A direction obeys R2 to R5 with b_in, b2a_ce_n, b2a_le_n and b2a_oe_n in place of the A-to-B signals, and with a_out and a_drv as its outputs.
- R7: The controls of section s affect only bits [s*8+7:s*8] of the banks and of the drive enables.
- R8: clash[s] is 1 exactly when both directions of section s are driving, that is, when the b_drv and a_drv bits of that section are all 1. The drive enables still follow R5 and R6 while the flag is up.
- R9: The output enables have no effect on capture. A value loaded while a2b_oe_n[s] is 1 appears on b_out once drive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the latches update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Data arriving on the A port |
| b_in | input | 16 | Data arriving on the B port |
| a2b_ce_n | input | 2 | A-to-B chip enable, one bit per section, active low |
| a2b_le_n | input | 2 | A-to-B latch enable, one bit per section, active low |
| a2b_oe_n | input | 2 | A-to-B output enable, one bit per section, active low |
| b2a_ce_n | input | 2 | B-to-A chip enable, one bit per section, active low |
| b2a_le_n | input | 2 | B-to-A latch enable, one bit per section, active low |
| b2a_oe_n | input | 2 | B-to-A output enable, one bit per section, active low |
| b_out | output | 16 | Contents of the A-to-B bank, presented toward B |
| b_drv | output | 16 | Per-bit drive enable for the B port, active high |
| a_out | output | 16 | Contents of the B-to-A bank, presented toward A |
| a_drv | output | 16 | Per-bit drive enable for the A port, active high |
| clash | output | 2 | Per-section flag set when both directions drive at once |

## Verification
The drive enables and the clash flags depend only on the inputs, so they are due in the same cycle as the control change. The bench changes inputs on the falling edge and checks these outputs one time unit later. Bank contents on b_out and a_out are due one rising edge after a capture. The bench updates its own model of each bank at that rising edge from the inputs it applied, and compares on the next falling edge, before it applies any new stimulus. Directed sequences then check that stored bytes survive changes on the input ports, that a disabled chip enable blocks capture, and that a byte loaded while its output is off shows up once drive is enabled.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   // A path stage is open when both of its active-low qualifiers are asserted.
   function automatic logic path_open(input logic sel_n, input logic gate_n);
      return (~sel_n) & (~gate_n);
   endfunction
endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             le_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q
);
   import xcvr_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_latch_bank: WIDTH must be at least 1");
      end
   endgenerate

   logic load;
   assign load = path_open(ce_n, le_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= d_in;
   end

   // R2: a transparent edge loads the input seen at that edge
   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !le_n) |=> (q == $past(d_in)));

   // R3 and R4: storage mode or a disabled chip keeps the contents
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || le_n) |=> $stable(q));
endmodule

// File: rtl/xcvr_drive_gate.sv
module xcvr_drive_gate #(
   parameter int WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   output logic [WIDTH-1:0] drv
);
   import xcvr_pkg::*;

   logic on;
   assign on  = rst_n & path_open(ce_n, oe_n);
   assign drv = {WIDTH{on}};

   // R1: nothing is driven while reset is held
   always_comb begin
      if (!rst_n) assert_reset_quiet_R1: assert (drv == '0);
   end
endmodule

// File: rtl/dual_lat_xcvr.sv
module dual_lat_xcvr #(
   parameter int SECT_W = 8,
   parameter int N_SECT = 2,
   localparam int BUS_W = SECT_W * N_SECT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  a_in,
   input  logic [BUS_W-1:0]  b_in,
   input  logic [N_SECT-1:0] a2b_ce_n,
   input  logic [N_SECT-1:0] a2b_le_n,
   input  logic [N_SECT-1:0] a2b_oe_n,
   input  logic [N_SECT-1:0] b2a_ce_n,
   input  logic [N_SECT-1:0] b2a_le_n,
   input  logic [N_SECT-1:0] b2a_oe_n,
   output logic [BUS_W-1:0]  b_out,
   output logic [BUS_W-1:0]  b_drv,
   output logic [BUS_W-1:0]  a_out,
   output logic [BUS_W-1:0]  a_drv,
   output logic [N_SECT-1:0] clash
);
   generate
      if (SECT_W < 1) begin : g_bad_sect_w
         $error("dual_lat_xcvr: SECT_W must be at least 1");
      end
      if (N_SECT < 1) begin : g_bad_n_sect
         $error("dual_lat_xcvr: N_SECT must be at least 1");
      end
   endgenerate

   for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      localparam int LO = s * SECT_W;

      xcvr_latch_bank #(.WIDTH(SECT_W)) u_ab_bank (
         .clk(clk), .rst_n(rst_n),
         .ce_n(a2b_ce_n[s]), .le_n(a2b_le_n[s]),
         .d_in(a_in[LO +: SECT_W]), .q(b_out[LO +: SECT_W]));

      xcvr_latch_bank #(.WIDTH(SECT_W)) u_ba_bank (
         .clk(clk), .rst_n(rst_n),
         .ce_n(b2a_ce_n[s]), .le_n(b2a_le_n[s]),
         .d_in(b_in[LO +: SECT_W]), .q(a_out[LO +: SECT_W]));

      xcvr_drive_gate #(.WIDTH(SECT_W)) u_b_gate (
         .rst_n(rst_n), .ce_n(a2b_ce_n[s]), .oe_n(a2b_oe_n[s]),
         .drv(b_drv[LO +: SECT_W]));

      xcvr_drive_gate #(.WIDTH(SECT_W)) u_a_gate (
         .rst_n(rst_n), .ce_n(b2a_ce_n[s]), .oe_n(b2a_oe_n[s]),
         .drv(a_drv[LO +: SECT_W]));

      assign clash[s] = b_drv[LO] & a_drv[LO];

      // R8: a raised flag means both ports of this section are fully driven
      assert_clash_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
         clash[s] |-> ((b_drv[LO +: SECT_W] == '1) && (a_drv[LO +: SECT_W] == '1)));

      // R7: drive enables of a section move as one byte
      assert_sect_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ((b_drv[LO +: SECT_W] == '0) || (b_drv[LO +: SECT_W] == '1)));
   end
endmodule

// File: tb/tb_dual_lat_xcvr.sv
module tb_dual_lat_xcvr;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 8;
   localparam int NS = 2;
   localparam int W = SW * NS;

   logic clk = 0;
   logic rst_n = 0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [NS-1:0] a2b_ce_n = '0, a2b_le_n = '0, a2b_oe_n = '0;
   logic [NS-1:0] b2a_ce_n = '0, b2a_le_n = '0, b2a_oe_n = '0;
   logic [W-1:0] b_out, b_drv, a_out, a_drv;
   logic [NS-1:0] clash;

   dual_lat_xcvr #(.SECT_W(SW), .N_SECT(NS)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .a2b_ce_n(a2b_ce_n), .a2b_le_n(a2b_le_n), .a2b_oe_n(a2b_oe_n),
      .b2a_ce_n(b2a_ce_n), .b2a_le_n(b2a_le_n), .b2a_oe_n(b2a_oe_n),
      .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
      .clash(clash));

   always #(CLK_PERIOD/2) clk = ~clk;

   int errs = 0, total = 0;
   bit finished = 0;
   logic [SW-1:0] m_ab [NS];
   logic [SW-1:0] m_ba [NS];
   string tag_ab [NS];
   string tag_ba [NS];

   task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      total++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [SW-1:0] drv_exp(input logic ce_n, input logic oe_n, input logic rst);
      return (rst && !ce_n && !oe_n) ? '1 : '0;
   endfunction

   task automatic check_comb();
      for (int s = 0; s < NS; s++) begin
         logic [SW-1:0] eb, ea;
         eb = drv_exp(a2b_ce_n[s], a2b_oe_n[s], rst_n);
         ea = drv_exp(b2a_ce_n[s], b2a_oe_n[s], rst_n);
         chk("R5", b_drv[s*SW +: SW], eb);
         chk("R6", a_drv[s*SW +: SW], ea);
         chk("R8", {7'd0, clash[s]}, {7'd0, eb[0] & ea[0]});
      end
   endtask

   task automatic update_model();
      for (int s = 0; s < NS; s++) begin
         if (!a2b_ce_n[s] && !a2b_le_n[s]) begin
            m_ab[s] = a_in[s*SW +: SW]; tag_ab[s] = "R2";
         end else if (a2b_ce_n[s]) tag_ab[s] = "R4";
         else tag_ab[s] = "R3";
         if (!b2a_ce_n[s] && !b2a_le_n[s]) m_ba[s] = b_in[s*SW +: SW];
         tag_ba[s] = "R6";
      end
   endtask

   task automatic check_data();
      for (int s = 0; s < NS; s++) begin
         chk(tag_ab[s], b_out[s*SW +: SW], m_ab[s]);
         chk(tag_ba[s], a_out[s*SW +: SW], m_ba[s]);
      end
   endtask

   // inputs were just set on a falling edge
   task automatic run_cycle();
      #1 check_comb();
      @(posedge clk);
      update_model();
      @(negedge clk);
      check_data();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errs, total);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errs++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [SW-1:0] held;
      void'($urandom(32'd4242));
      for (int s = 0; s < NS; s++) begin m_ab[s] = '0; m_ba[s] = '0; end
      // R1: all controls ask to load and drive, reset must win
      a_in = 16'hA5C3; b_in = 16'h3C5A;
      repeat (3) @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         chk("R1", b_out[s*SW +: SW], '0);
         chk("R1", a_out[s*SW +: SW], '0);
         chk("R1", b_drv[s*SW +: SW], '0);
         chk("R1", a_drv[s*SW +: SW], '0);
         chk("R1", {7'd0, clash[s]}, 8'd0);
      end
      // hold everything while leaving reset
      a2b_le_n = '1; b2a_le_n = '1;
      rst_n = 1;
      run_cycle();

      // R7: section 0 transparent, section 1 stores; A input keeps changing
      a2b_ce_n = 2'b00; a2b_le_n = 2'b00; a2b_oe_n = 2'b00; a_in = 16'h7711;
      run_cycle();
      a2b_le_n = 2'b10;
      held = b_out[15:8];
      for (int i = 0; i < 4; i++) begin
         a_in = 16'(32'h1234 * (i + 3));
         run_cycle();
         chk("R7", b_out[15:8], held);
         chk("R7", b_out[7:0], a_in[7:0]);
      end

      // R4: chip disabled with latch enable low, input changes ignored
      a2b_ce_n = 2'b11; a2b_le_n = 2'b00;
      held = b_out[7:0];
      a_in = 16'hFFEE;
      run_cycle();
      a2b_ce_n = 2'b00; a2b_le_n = 2'b11;
      run_cycle();
      chk("R4", b_out[7:0], held);

      // R9: load with output off, then turn output on
      a2b_oe_n = 2'b11; a2b_le_n = 2'b00; a_in = 16'h9C6D;
      run_cycle();
      a2b_le_n = 2'b11; a2b_oe_n = 2'b00; a_in = 16'h0000;
      run_cycle();
      chk("R9", b_out[15:8], 8'h9C);
      chk("R9", b_drv[15:8], 8'hFF);

      // R8: both directions of section 1 drive
      a2b_ce_n = 2'b00; a2b_oe_n = 2'b01; b2a_ce_n = 2'b00; b2a_oe_n = 2'b01;
      run_cycle();
      chk("R8", {7'd0, clash[1]}, 8'd1);
      chk("R8", {7'd0, clash[0]}, 8'd0);

      // random mix against the model
      for (int n = 0; n < 3000; n++) begin
         a_in = 16'($urandom); b_in = 16'($urandom);
         a2b_ce_n = 2'(($urandom % 4 == 0) ? 2'b11 : $urandom);
         a2b_le_n = 2'($urandom); a2b_oe_n = 2'($urandom);
         b2a_ce_n = 2'(($urandom % 4 == 0) ? 2'b11 : $urandom);
         b2a_le_n = 2'($urandom); b2a_oe_n = 2'($urandom);
         run_cycle();
      end
      finish_run();
   end
endmodule